// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounding Unit

This is a purely combinational rounding stage for a floating-point datapath. It takes a mantissa with two extra low-order bits, a guard bit and a round bit, plus a separately carried sticky bit, the operand sign, and a 2-bit rounding-mode code. It drops the two extra bits, decides whether the truncated mantissa must be incremented under the selected mode, and returns the rounded mantissa with a separate carry-out.

Alongside the value it reports a rounded-up flag, a fraction-rounded status flag, and a pair of inexact status flags. When the increment overflows the mantissa, which is the 2.0 case, the carry is passed out as-is. Renormalising that result, packing it into a storage format, and trapping on the flags are left to the stages that follow.

Top module: `dru_round_unit`

## Requirements
- R1: When no increment happens, `rnd_mant` equals the input mantissa shifted right by two. Bit 1 of the input is the guard bit and bit 0 is the round bit. `rnd_carry` is 0 in this case.
- R2: When guard, round and sticky are all 0, there is no increment, and `rnd_up`, `flag_frac_rnd`, `flag_inexact` and `flag_frac_inexact` are all 0.
- R3: When any of guard, round or sticky is 1, both `flag_inexact` and `flag_frac_inexact` are 1.
- R4: Mode code 2'b00 is nearest-even. It increments only when guard is 1 and at least one of these is 1: round, sticky, or the LSB of the shifted mantissa.
- R5: Mode code 2'b01 rounds toward zero and never increments.
- R6: Mode code 2'b10 rounds toward plus infinity. It increments exactly when the result is inexact and `op_sign` is 0.
- R7: Mode code 2'b11 rounds toward minus infinity. It increments exactly when the result is inexact and `op_sign` is 1.
- R8: On an increment, `rnd_up` and `flag_frac_rnd` are both 1, and {`rnd_carry`, `rnd_mant`} equals the shifted mantissa plus one. Otherwise both flags are 0.
- R9: If the shifted mantissa is all ones and an increment happens, `rnd_carry` is 1 and `rnd_mant` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sign | input | 1 | Sign of the operand, 1 = negative |
| op_mant | input | MANT_W+2 | Mantissa; bit 1 is the guard bit, bit 0 is the round bit |
| op_sticky | input | 1 | OR of all bits below the round bit |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| rnd_mant | output | MANT_W | Rounded mantissa, without the carry |
| rnd_carry | output | 1 | Carry out of the increment (the 2.0 case) |
| rnd_up | output | 1 | An increment was applied |
| flag_inexact | output | 1 | Inexact status |
| flag_frac_inexact | output | 1 | Fraction-inexact status |
| flag_frac_rnd | output | 1 | Fraction-rounded status |

## Verification
The tests cover exact operands with a zero tail, which separate a truncation-only path from the flag logic. Every guard/round/sticky combination is run against odd and even LSBs under nearest-even, which tells a true tie-to-even apart from plain round-half-up. Both signs are driven in each directed mode, so that a swapped plus/minus decision shows up, and all-ones mantissas force the carry to 2.0. Random operands in all four modes are compared against an integer model kept in the bench.

// File: rtl/dru_pkg.sv
package dru_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_POS  = 2'b10,
        RM_NEG  = 2'b11
    } rmode_e;

    // Bits the rounding decision depends on
    typedef struct packed {
        logic guard;
        logic rnd;
        logic sticky;
        logic lsb;
        logic sign;
    } rbits_t;

    // Outcome of the decision stage
    typedef struct packed {
        logic inexact;
        logic bump;
    } rdec_t;

    // Map a raw code to a mode; codes outside the set fall back to nearest
    function automatic rmode_e to_mode(input logic [1:0] code);
        rmode_e m;
        case (code)
            2'b01:   m = RM_ZERO;
            2'b10:   m = RM_POS;
            2'b11:   m = RM_NEG;
            default: m = RM_NEAR;
        endcase
        return m;
    endfunction

    function automatic logic tail_nonzero(input rbits_t b);
        return b.guard | b.rnd | b.sticky;
    endfunction

    // Nearest-even: above half, or exactly half with an odd LSB
    function automatic logic near_even_bump(input rbits_t b);
        return b.guard & (b.rnd | b.sticky | b.lsb);
    endfunction

endpackage

// File: rtl/dru_split.sv
module dru_split
    import dru_pkg::*;
#(
    parameter int MANT_W = 24
) (
    input  logic              sign_i,
    input  logic [MANT_W+1:0] mant_i,
    input  logic              sticky_i,
    output logic [MANT_W-1:0] trunc_o,
    output rbits_t            bits_o
);
    localparam int EXTRA = 2;

    always_comb begin
        trunc_o       = mant_i[MANT_W+EXTRA-1:EXTRA];
        bits_o.guard  = mant_i[1];
        bits_o.rnd    = mant_i[0];
        bits_o.sticky = sticky_i;
        bits_o.lsb    = mant_i[EXTRA];
        bits_o.sign   = sign_i;
    end
endmodule

// File: rtl/dru_decide.sv
module dru_decide
    import dru_pkg::*;
(
    input  rbits_t     bits_i,
    input  logic [1:0] code_i,
    output rdec_t      dec_o
);
    rmode_e mode;

    always_comb begin
        mode        = to_mode(code_i);
        dec_o.inexact = tail_nonzero(bits_i);
        dec_o.bump    = 1'b0;
        if (dec_o.inexact) begin
            unique case (mode)
                RM_NEAR: dec_o.bump = near_even_bump(bits_i);
                RM_ZERO: dec_o.bump = 1'b0;
                RM_POS:  dec_o.bump = ~bits_i.sign;
                RM_NEG:  dec_o.bump = bits_i.sign;
            endcase
        end
    end
endmodule

// File: rtl/dru_incr.sv
module dru_incr #(
    parameter int MANT_W = 24
) (
    input  logic [MANT_W-1:0] val_i,
    input  logic              bump_i,
    output logic [MANT_W-1:0] sum_o,
    output logic              carry_o
);
    localparam int SUM_W = MANT_W + 1;

    logic [SUM_W-1:0] wide;

    always_comb begin
        wide    = {1'b0, val_i} + {{MANT_W{1'b0}}, bump_i};
        sum_o   = wide[MANT_W-1:0];
        carry_o = wide[SUM_W-1];
    end
endmodule

// File: rtl/dru_round_unit.sv
module dru_round_unit
    import dru_pkg::*;
#(
    parameter int MANT_W = 24
) (
    input  logic              op_sign,
    input  logic [MANT_W+1:0] op_mant,
    input  logic              op_sticky,
    input  logic [1:0]        rnd_mode,
    output logic [MANT_W-1:0] rnd_mant,
    output logic              rnd_carry,
    output logic              rnd_up,
    output logic              flag_inexact,
    output logic              flag_frac_inexact,
    output logic              flag_frac_rnd
);
    logic [MANT_W-1:0] trunc;
    rbits_t            bits;
    rdec_t             dec;

    dru_split #(.MANT_W(MANT_W)) u_split (
        .sign_i   (op_sign),
        .mant_i   (op_mant),
        .sticky_i (op_sticky),
        .trunc_o  (trunc),
        .bits_o   (bits)
    );

    dru_decide u_decide (
        .bits_i (bits),
        .code_i (rnd_mode),
        .dec_o  (dec)
    );

    dru_incr #(.MANT_W(MANT_W)) u_incr (
        .val_i   (trunc),
        .bump_i  (dec.bump),
        .sum_o   (rnd_mant),
        .carry_o (rnd_carry)
    );

    always_comb begin
        rnd_up            = dec.bump;
        flag_frac_rnd     = dec.bump;
        flag_inexact      = dec.inexact;
        flag_frac_inexact = dec.inexact;
    end

    always_comb begin
        if (!(op_mant[1] | op_mant[0] | op_sticky))
            AST_EXACT_QUIET: assert (!rnd_up && !flag_inexact && !rnd_carry); // R2
        if (rnd_mode == 2'b01)
            AST_TOWARD_ZERO_HOLDS: assert (!rnd_up && rnd_mant == op_mant[MANT_W+1:2]); // R5
        if (rnd_mode == 2'b10 && op_sign)
            AST_POS_NEG_SIGN_HOLDS: assert (!rnd_up); // R6
        if (rnd_mode == 2'b11 && !op_sign)
            AST_NEG_POS_SIGN_HOLDS: assert (!rnd_up); // R7
        if (rnd_up)
            AST_UP_NEEDS_INEXACT: assert (flag_inexact && flag_frac_inexact); // R8
        if (rnd_carry)
            AST_CARRY_WRAPS_ZERO: assert (rnd_up && rnd_mant == '0 && &op_mant[MANT_W+1:2]); // R9
    end
endmodule

// File: tb/dru_round_unit_test.sv
module dru_round_unit_test;
    localparam int MW = 24;
    localparam int IW = MW + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          op_sign, op_sticky;
    logic [IW-1:0] op_mant;
    logic [1:0]    rnd_mode;
    logic [MW-1:0] rnd_mant;
    logic          rnd_carry, rnd_up, flag_inexact, flag_frac_inexact, flag_frac_rnd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    dru_round_unit #(.MANT_W(MW)) uut (
        .op_sign(op_sign), .op_mant(op_mant), .op_sticky(op_sticky), .rnd_mode(rnd_mode),
        .rnd_mant(rnd_mant), .rnd_carry(rnd_carry), .rnd_up(rnd_up),
        .flag_inexact(flag_inexact), .flag_frac_inexact(flag_frac_inexact),
        .flag_frac_rnd(flag_frac_rnd)
    );

    // Integer model: value = m/4 with sticky below; decide per mode
    task automatic expect_of(input logic s, input logic [IW-1:0] m, input logic st,
                             input logic [1:0] md, output longint exp_val, output bit exp_up,
                             output bit exp_inx);
        longint base, rem;
        base    = longint'(m) / 4;
        rem     = longint'(m) % 4;
        exp_inx = (rem != 0) || st;
        case (md)
            2'b00:   exp_up = (rem > 2) || (rem == 2 && (st || (base % 2 == 1)));
            2'b01:   exp_up = 0;
            2'b10:   exp_up = exp_inx && !s;
            default: exp_up = exp_inx && s;
        endcase
        exp_val = base + (exp_up ? 1 : 0);
    endtask

    task automatic apply_check(input logic s, input logic [IW-1:0] m, input logic st,
                               input logic [1:0] md, input string req);
        longint ev, got;
        bit eu, ei;
        @(negedge clk);
        op_sign = s; op_mant = m; op_sticky = st; rnd_mode = md;
        @(posedge clk);
        #1;
        expect_of(s, m, st, md, ev, eu, ei);
        got = longint'({rnd_carry, rnd_mant});
        checks++;
        if (got != ev || rnd_up != eu || flag_frac_rnd != eu ||
            flag_inexact != ei || flag_frac_inexact != ei) begin
            errors++;
            $display("FAIL %s: mode=%b sign=%b mant=%h st=%b got val=%h up=%b fr=%b ix=%b fi=%b exp val=%h up=%b ix=%b",
                     req, md, s, m, st, got, rnd_up, flag_frac_rnd, flag_inexact,
                     flag_frac_inexact, ev, eu, ei);
        end
    endtask

    task automatic test_reset_state();
        // R2: all-zero operand while reset is held gives zero outputs
        apply_check(0, '0, 0, 2'b00, "R2 reset");
    endtask

    task automatic test_exact();
        for (int md = 0; md < 4; md++) begin
            apply_check(0, {24'h5A5A5A, 2'b00}, 0, md[1:0], "R1 R2 exact");
            apply_check(1, {24'hFFFFFF, 2'b00}, 0, md[1:0], "R2 exact all-ones");
        end
    endtask

    task automatic test_nearest();
        for (int gr = 0; gr < 4; gr++)
            for (int st = 0; st < 2; st++) begin
                apply_check(0, {24'h100002, gr[1:0]}, st[0], 2'b00, "R4 R3 even lsb");
                apply_check(1, {24'h100003, gr[1:0]}, st[0], 2'b00, "R4 R3 odd lsb");
            end
    endtask

    task automatic test_toward_zero();
        apply_check(0, {24'h123457, 2'b11}, 1, 2'b01, "R5 pos");
        apply_check(1, {24'hFFFFFF, 2'b10}, 1, 2'b01, "R5 neg all-ones");
        apply_check(0, {24'h000000, 2'b01}, 0, 2'b01, "R5 R3 round only");
    endtask

    task automatic test_plus_inf();
        apply_check(0, {24'h000010, 2'b00}, 1, 2'b10, "R6 pos sticky");
        apply_check(1, {24'h000010, 2'b00}, 1, 2'b10, "R6 neg sticky");
        apply_check(0, {24'h000011, 2'b01}, 0, 2'b10, "R6 R8 pos round");
        apply_check(1, {24'h000011, 2'b11}, 0, 2'b10, "R6 neg gr");
    endtask

    task automatic test_minus_inf();
        apply_check(1, {24'h000010, 2'b00}, 1, 2'b11, "R7 neg sticky");
        apply_check(0, {24'h000010, 2'b00}, 1, 2'b11, "R7 pos sticky");
        apply_check(1, {24'h7FFFFF, 2'b10}, 0, 2'b11, "R7 R8 neg guard");
        apply_check(0, {24'h7FFFFF, 2'b11}, 0, 2'b11, "R7 pos gr");
    endtask

    task automatic test_carry();
        apply_check(0, {24'hFFFFFF, 2'b11}, 0, 2'b00, "R9 nearest");
        apply_check(0, {24'hFFFFFF, 2'b00}, 1, 2'b10, "R9 plus");
        apply_check(1, {24'hFFFFFF, 2'b01}, 0, 2'b11, "R9 minus");
        apply_check(0, {24'hFFFFFF, 2'b10}, 0, 2'b00, "R9 R4 odd tie");
    endtask

    task automatic test_random();
        for (int i = 0; i < 2000; i++) begin
            logic [IW-1:0] m;
            m = IW'($urandom);
            if (i % 8 == 0) m[IW-1:2] = '1;
            apply_check($urandom % 2, m, $urandom % 2, 2'($urandom), "R8 random");
        end
    endtask

    initial begin
        op_sign = 0; op_mant = '0; op_sticky = 0; rnd_mode = 2'b00;
        test_reset_state();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        test_exact();
        test_nearest();
        test_toward_zero();
        test_plus_inf();
        test_minus_inf();
        test_carry();
        test_random();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule